// File: doc/BRIEF.md
# Serial Test-Pattern Sync Monitor

The monitor receives a serial bit stream, one bit per cycle in which a valid strobe is high, and compares each bit with a locally generated reference. The reference is a 32-bit shift register that produces pseudo-random sequences from two programmable taps, a fixed 20-stage QRSS-style sequence, or a repeating word of programmable length. The bit the register expects next is its own feedback value. This lets the register lock onto a stream that starts at any phase.

While the monitor is out of synchronization, the reference register shifts in the received bits so that it takes on the phase of the sender. Once it has seen a long enough run of matching bits, the monitor declares synchronization and the register runs free on its own feedback. From then on, every received bit is counted, and every disagreement is counted as a bit error and signalled with a one-cycle pulse. Bit errors can take the monitor out of synchronization. The rule for this depends on the pattern type. Both counters freeze while the monitor is out of sync, saturate at their maximum value, and are zeroed by a clear pulse.

Top module: `pat_sync_mon`

## Requirements
- R1: After reset, `oos` is 1, both counters are 0, `err_pulse` is 0, and the reference register holds all ones.
- R2: The expected bit is the feedback of the reference register. Register bit 1 holds the newest bit, and `tap_n`/`tap_y` hold a tap position minus one. With `mode`=0 (PRBS), the feedback is bit(`tap_n`+1) XOR bit(`tap_y`+1). With `mode`=1 (QRSS), it is bit 17 XOR bit 20, and the tap inputs are ignored. With `mode`=2 or 3 (repetitive), it is bit(`tap_n`+1), so the pattern length is `tap_n`+1. In modes 0 and 1, the feedback is forced to 1 whenever bits 1 to 31 are all zero.
- R3: While `oos`=1, each valid bit is shifted into the reference register, so the monitor acquires a stream that starts at any phase. While in sync, the register shifts in its own feedback.
- R4: Out of sync, 32 consecutive matching valid bits set `oos` to 0 in the cycle after the 32nd bit. Any mismatch restarts this run.
- R5: In sync, each valid bit adds 1 to `bit_cnt`. A mismatching bit also adds 1 to `err_cnt` and sets `err_pulse` high for the following cycle.
- R6: While `oos`=1, neither counter changes and `err_pulse` stays 0.
- R7: In the repetitive modes, a single mismatch while in sync sets `oos` to 1. That bit is still counted.
- R8: In modes 0 and 1, the sixth mismatch inside a 64-bit window sets `oos` to 1. Windows are fixed 64-bit blocks that start when sync is gained. Five mismatches per window keep the monitor in sync.
- R9: Both counters saturate at all ones.
- R10: `cnt_clr` zeroes both counters in the next cycle, even when a counted bit arrives in the same cycle.
- R11: Cycles with `din_vld`=0 have no effect, whatever the value on `din`.
- R12: In mode 0, a stream of all zeros never brings the monitor into sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Received data bit |
| din_vld | input | 1 | `din` carries a bit this cycle |
| mode | input | 2 | 0 PRBS, 1 QRSS, 2/3 repetitive |
| tap_n | input | TAP_W (5) | First tap position minus one, or repeat length minus one |
| tap_y | input | TAP_W (5) | Second PRBS tap position minus one |
| cnt_clr | input | 1 | Zero both counters |
| oos | output | 1 | Out of synchronization |
| bit_cnt | output | CNT_W (32) | Bits counted while in sync |
| err_cnt | output | CNT_W (32) | Bit errors counted while in sync |
| err_pulse | output | 1 | One-cycle pulse after each counted error |

## Verification
The hardest condition to reach from the ports is loss of sync through the error window in PRBS mode. Reaching it requires exactly six errors to fall in the same fixed 64-bit block, which starts at the moment of lock. The bench locks the monitor deterministically by starting its own reference sequence at the same all-ones state as the monitor, so the window boundaries are known to the bit. It then places errors on both sides of a boundary to show that the window restarts, and places six errors inside one window to force the drop. Saturation of the error counter needs hundreds of errors without losing sync. To reach it, the bench narrows the counters and inserts five errors into each of many consecutive windows.

// File: rtl/psm_pkg.sv
package psm_pkg;
    localparam logic [1:0] MODE_PRBS = 2'd0;
    localparam logic [1:0] MODE_QRSS = 2'd1;

    typedef enum logic {
        ST_VERIFY = 1'b0,
        ST_SYNC   = 1'b1
    } sync_e;
endpackage

// File: rtl/psm_refgen.sv
module psm_refgen
    import psm_pkg::*;
#(
    parameter int REG_W  = 32,
    parameter int TAP_W  = $clog2(REG_W),
    parameter int QTAP_A = 17,
    parameter int QTAP_B = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic             din,
    input  logic [1:0]       mode,
    input  logic [TAP_W-1:0] tap_n,
    input  logic [TAP_W-1:0] tap_y,
    output logic             exp_bit
);
    localparam int QA = QTAP_A - 1;
    localparam int QB = QTAP_B - 1;

    logic [REG_W-1:0] sr_d, sr_q;
    logic             fb;
    logic             is_rep;
    logic             zero_run;

    always_comb begin
        is_rep   = mode[1];
        zero_run = (sr_q[REG_W-2:0] == '0);
        if (mode == MODE_PRBS) begin
            fb = sr_q[tap_n] ^ sr_q[tap_y];
        end else if (mode == MODE_QRSS) begin
            fb = sr_q[QA] ^ sr_q[QB];
        end else begin
            fb = sr_q[tap_n];
        end
        if (!is_rep && zero_run) begin
            fb = 1'b1;
        end
        sr_d = sr_q;
        if (adv) begin
            sr_d = {sr_q[REG_W-2:0], (load ? din : fb)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= sr_d;
    end

    assign exp_bit = fb;

    // R3: out of sync, the received bit enters the register
    a_r3_load_din: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && load) |=> (sr_q[0] == $past(din)));

    // R3: in sync, the register keeps the value it predicted
    a_r3_free_run: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (sr_q[0] == $past(exp_bit)));
endmodule

// File: rtl/psm_syncfsm.sv
module psm_syncfsm
    import psm_pkg::*;
#(
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int WIN_LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic mis,
    input  logic is_rep,
    output logic in_sync
);
    localparam int RUN_W  = $clog2(LOCK_RUN);
    localparam int WPOS_W = $clog2(WIN_LEN);
    localparam int WERR_W = $clog2(WIN_LIMIT + 1);

    typedef struct packed {
        sync_e             state;
        logic [RUN_W-1:0]  run;
        logic [WPOS_W-1:0] wpos;
        logic [WERR_W-1:0] werr;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        if (adv) begin
            if (q.state == ST_VERIFY) begin
                if (mis) begin
                    d.run = '0;
                end else if (q.run == RUN_W'(LOCK_RUN - 1)) begin
                    d.state = ST_SYNC;
                    d.run   = '0;
                    d.wpos  = '0;
                    d.werr  = '0;
                end else begin
                    d.run = q.run + 1'b1;
                end
            end else if (is_rep) begin
                if (mis) begin
                    d.state = ST_VERIFY;
                    d.run   = '0;
                end
            end else begin
                if (mis && (q.werr == WERR_W'(WIN_LIMIT - 1))) begin
                    d.state = ST_VERIFY;
                    d.run   = '0;
                end else if (q.wpos == WPOS_W'(WIN_LEN - 1)) begin
                    d.wpos = '0;
                    d.werr = '0;
                end else begin
                    d.wpos = q.wpos + 1'b1;
                    d.werr = q.werr + WERR_W'(mis);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: ST_VERIFY, run: '0, wpos: '0, werr: '0};
        else        q <= d;
    end

    assign in_sync = (q.state == ST_SYNC);

    // R4: sync is entered only at the end of a full matching run
    a_r4_lock_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.state == ST_SYNC) |-> ($past(q.run) == RUN_W'(LOCK_RUN - 1) && $past(!mis)));

    // R7: a repetitive-mode error in sync drops sync
    a_r7_rep_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rep && q.state == ST_SYNC && adv && mis) |=> (q.state == ST_VERIFY));

    // R8: a matching bit never drops sync
    a_r8_match_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SYNC && adv && !mis) |=> (q.state == ST_SYNC));
endmodule

// File: rtl/psm_counters.sv
module psm_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             mis,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_pulse
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] bits;
        logic [CNT_W-1:0] errs;
        logic             pulse;
    } cnt_t;

    cnt_t d, q;

    always_comb begin
        d       = q;
        d.pulse = en & mis;
        if (clr) begin
            d.bits = '0;
            d.errs = '0;
        end else if (en) begin
            if (q.bits != CNT_MAX) d.bits = q.bits + 1'b1;
            if (mis && q.errs != CNT_MAX) d.errs = q.errs + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_cnt   = q.bits;
    assign err_cnt   = q.errs;
    assign err_pulse = q.pulse;

    // R9: a saturated counter holds its value
    a_r9_bits_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (q.bits == CNT_MAX && !clr) |=> (q.bits == CNT_MAX));

    // R10: a clear wins over counting
    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.bits == '0 && q.errs == '0));

    // R5: errors never outnumber counted bits
    a_r5_err_le_bits: assert property (@(posedge clk) disable iff (!rst_n)
        q.errs <= q.bits);
endmodule

// File: rtl/pat_sync_mon.sv
module pat_sync_mon #(
    parameter int REG_W     = 32,
    parameter int TAP_W     = $clog2(REG_W),
    parameter int CNT_W     = 32,
    parameter int LOCK_RUN  = 32,
    parameter int WIN_LEN   = 64,
    parameter int WIN_LIMIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic             din_vld,
    input  logic [1:0]       mode,
    input  logic [TAP_W-1:0] tap_n,
    input  logic [TAP_W-1:0] tap_y,
    input  logic             cnt_clr,
    output logic             oos,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [CNT_W-1:0] err_cnt,
    output logic             err_pulse
);
    logic exp_bit;
    logic mis;
    logic in_sync;

    assign mis = din ^ exp_bit;
    assign oos = ~in_sync;

    psm_refgen #(
        .REG_W (REG_W),
        .TAP_W (TAP_W)
    ) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (din_vld),
        .load    (~in_sync),
        .din     (din),
        .mode    (mode),
        .tap_n   (tap_n),
        .tap_y   (tap_y),
        .exp_bit (exp_bit)
    );

    psm_syncfsm #(
        .LOCK_RUN  (LOCK_RUN),
        .WIN_LEN   (WIN_LEN),
        .WIN_LIMIT (WIN_LIMIT)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (din_vld),
        .mis     (mis),
        .is_rep  (mode[1]),
        .in_sync (in_sync)
    );

    psm_counters #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .en        (din_vld & in_sync),
        .mis       (mis),
        .bit_cnt   (bit_cnt),
        .err_cnt   (err_cnt),
        .err_pulse (err_pulse)
    );

    // R6: counters frozen while out of sync
    a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (oos && !cnt_clr) |=> ($stable(bit_cnt) && $stable(err_cnt) && !err_pulse));

    // R11: an idle cycle changes nothing
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_vld && !cnt_clr) |=> ($stable(oos) && $stable(bit_cnt) && $stable(err_cnt)));
endmodule

// File: tb/pat_sync_mon_test.sv
module pat_sync_mon_test;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b0;
    logic          din_vld = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [4:0]    tap_n = 5'd14;
    logic [4:0]    tap_y = 5'd13;
    logic          cnt_clr = 1'b0;
    logic          oos;
    logic [CW-1:0] bit_cnt;
    logic [CW-1:0] err_cnt;
    logic          err_pulse;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] g;
    int gn, gy;

    always #4 clk = ~clk;

    pat_sync_mon #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
        .mode(mode), .tap_n(tap_n), .tap_y(tap_y), .cnt_clr(cnt_clr),
        .oos(oos), .bit_cnt(bit_cnt), .err_cnt(err_cnt), .err_pulse(err_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] m, input int n, input int y);
        rst_n = 1'b0; din_vld = 1'b0; cnt_clr = 1'b0; din = 1'b0;
        mode = m; tap_n = 5'(n - 1); tap_y = 5'(y - 1);
        g = '1; gn = n; gy = y;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic gen_bit(output logic b);
        logic fb;
        fb = g[gn-1] ^ g[gy-1];
        if (g[30:0] == 31'd0) fb = 1'b1;
        g = {g[30:0], fb};
        b = fb;
    endtask

    task automatic send(input logic b);
        din = b; din_vld = 1'b1;
        @(posedge clk); #1;
        din_vld = 1'b0;
    endtask

    task automatic send_gen(input logic flip);
        logic b;
        gen_bit(b);
        send(b ^ flip);
    endtask

    task automatic clr_cnt();
        cnt_clr = 1'b1;
        @(posedge clk); #1;
        cnt_clr = 1'b0;
    endtask

    task automatic lock_prbs15();
        do_reset(2'd0, 15, 14);
        repeat (32) send_gen(1'b0);
        clr_cnt();
    endtask

    task automatic t_reset();
        do_reset(2'd0, 15, 14);
        chk("R1 oos", oos, 1);
        chk("R1 bit_cnt", bit_cnt, 0);
        chk("R1 err_cnt", err_cnt, 0);
        chk("R1 err_pulse", err_pulse, 0);
    endtask

    task automatic t_lock();
        do_reset(2'd0, 15, 14);
        repeat (31) send_gen(1'b0);
        chk("R4 oos after 31", oos, 1);
        chk("R6 frozen bit_cnt", bit_cnt, 0);
        send_gen(1'b0);
        chk("R4 R1 R2 oos after 32", oos, 0);
        chk("R4 no count at lock bit", bit_cnt, 0);
        repeat (5) send_gen(1'b0);
        chk("R5 bit_cnt", bit_cnt, 5);
    endtask

    task automatic t_count();
        lock_prbs15();
        repeat (50) send_gen(1'b0);
        chk("R5 clean bits", bit_cnt, 50);
        chk("R5 clean errs", err_cnt, 0);
        for (int i = 0; i < 20; i++) begin
            send_gen(i == 3 || i == 9 || i == 15);
            chk("R5 err_pulse", err_pulse, (i == 3 || i == 9 || i == 15) ? 1 : 0);
        end
        chk("R5 bits", bit_cnt, 70);
        chk("R5 errs", err_cnt, 3);
        chk("R8 three errors keep sync", oos, 0);
    endtask

    task automatic t_window_drop();
        lock_prbs15();
        repeat (10) send_gen(1'b0);
        repeat (5) send_gen(1'b1);
        chk("R8 five errors keep sync", oos, 0);
        send_gen(1'b1);
        chk("R8 sixth error drops", oos, 1);
        chk("R8 bits", bit_cnt, 16);
        chk("R8 errs", err_cnt, 6);
        repeat (31) send_gen(1'b0);
        chk("R6 frozen bits", bit_cnt, 16);
        chk("R6 frozen errs", err_cnt, 6);
        chk("R4 relock pending", oos, 1);
        send_gen(1'b0);
        chk("R4 relock", oos, 0);
    endtask

    task automatic t_window_restart();
        lock_prbs15();
        repeat (5) send_gen(1'b1);
        repeat (59) send_gen(1'b0);
        repeat (5) send_gen(1'b1);
        chk("R8 new window keeps sync", oos, 0);
        chk("R8 errs", err_cnt, 10);
        chk("R8 bits", bit_cnt, 69);
        send_gen(1'b1);
        chk("R8 sixth in window drops", oos, 1);
        chk("R8 errs after drop", err_cnt, 11);
    endtask

    task automatic t_offset_acquire();
        logic b;
        do_reset(2'd0, 15, 14);
        for (int i = 0; i < 100; i++) gen_bit(b);
        repeat (60) send_gen(1'b0);
        chk("R3 acquire at offset", oos, 0);
    endtask

    task automatic t_qrss();
        do_reset(2'd1, 20, 17);
        tap_n = 5'd2; tap_y = 5'd7;
        repeat (31) send_gen(1'b0);
        chk("R2 qrss not yet", oos, 1);
        send_gen(1'b0);
        chk("R2 qrss lock", oos, 0);
        repeat (40) send_gen(1'b0);
        chk("R2 qrss clean", err_cnt, 0);
        chk("R2 qrss bits", bit_cnt, 40);
    endtask

    task automatic t_repeat();
        logic [7:0] pat;
        int k;
        pat = 8'hB2; k = 0;
        do_reset(2'd2, 8, 1);
        repeat (48) begin send(pat[k % 8]); k++; end
        chk("R2 repetitive lock", oos, 0);
        clr_cnt();
        repeat (16) begin send(pat[k % 8]); k++; end
        send(~pat[k % 8]); k++;
        chk("R7 single error drops", oos, 1);
        chk("R7 bits", bit_cnt, 17);
        chk("R7 errs", err_cnt, 1);
        chk("R7 err_pulse", err_pulse, 1);
        repeat (31) begin send(pat[k % 8]); k++; end
        chk("R7 relock pending", oos, 1);
        chk("R6 frozen", bit_cnt, 17);
        send(pat[k % 8]); k++;
        chk("R7 relock", oos, 0);
    endtask

    task automatic t_zero_stream();
        do_reset(2'd0, 15, 14);
        repeat (100) send(1'b0);
        chk("R12 zeros never lock", oos, 1);
        chk("R12 no count", bit_cnt, 0);
    endtask

    task automatic t_idle();
        lock_prbs15();
        repeat (10) send_gen(1'b0);
        for (int i = 0; i < 20; i++) begin
            din = i[0]; din_vld = 1'b0;
            @(posedge clk); #1;
        end
        chk("R11 idle bits", bit_cnt, 10);
        chk("R11 idle oos", oos, 0);
        chk("R11 idle pulse", err_pulse, 0);
        repeat (10) send_gen(1'b0);
        chk("R11 resume errs", err_cnt, 0);
        chk("R11 resume bits", bit_cnt, 20);
    endtask

    task automatic t_clear();
        lock_prbs15();
        repeat (10) send_gen(1'b1 == 1'b0);
        cnt_clr = 1'b1;
        send_gen(1'b0);
        cnt_clr = 1'b0;
        chk("R10 clear with bit", bit_cnt, 0);
        send_gen(1'b0);
        chk("R10 count after clear", bit_cnt, 1);
    endtask

    task automatic t_saturate();
        lock_prbs15();
        for (int w = 0; w < 55; w++) begin
            for (int i = 0; i < 64; i++) send_gen(i < 5);
        end
        chk("R9 bits sat", bit_cnt, 255);
        chk("R9 errs sat", err_cnt, 255);
        chk("R8 five per window keeps sync", oos, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_lock();
        t_count();
        t_window_drop();
        t_window_restart();
        t_offset_acquire();
        t_qrss();
        t_repeat();
        t_zero_stream();
        t_idle();
        t_clear();
        t_saturate();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule